// File: doc/BRIEF.md
# Sliding-Window Tone Packet Qualifier

This block sits behind a tone detector that hands over one verdict per packet: a strobe together with a flag that says whether the packet held good tone. The block keeps a short history of these flags and holds a running count of the good ones inside a sliding window. It drives an active-low detect line. The line goes low only when enough good packets fall inside the window. Isolated bursts of tone do not qualify, and a few bad packets inside a long tone do not drop the output.

A packet lasts 32 periods of the metering tone. In 16 kHz operation that is 2 ms, so 24 packets span 48 ms and 20 good packets make up 40 ms of good tone. In 12 kHz operation a packet lasts about 2.667 ms, so 18 packets span the window and 15 packets are required. The count is re-evaluated at every accepted packet. When the good packets arrive back to back, the output goes low at the packet that reaches the threshold, which is 40 ms after the tone starts.

A change of the mode input discards the history, because a window gathered at one packet rate is meaningless at the other.

Top module: `pkt_window_qual`

## Requirements
- R1: After synchronous reset `det_n` is 1 and the packet history and count are empty.
- R2: With `sys_12k`=0 (16 kHz, window 24, threshold 20), a run of good packets drives `det_n` to 0 at the clock edge that accepts the 20th good packet. It stays 1 after the 19th.
- R3: With `sys_12k`=1 (12 kHz, window 18, threshold 15), a run of good packets drives `det_n` to 0 at the edge that accepts the 15th good packet. It stays 1 after the 14th.
- R4: After each accepted packet, `det_n` is 0 exactly when at least the threshold number of the most recent window-length packets are good (`pkt_good`=1). The bad packets may fall anywhere in the window.
- R5: Once qualified, `det_n` returns to 1 at the packet update where the good count in the window falls below the threshold. In 16 kHz mode that is the 5th bad packet after a run of exactly 20 good packets.
- R6: The window slides by one packet at every accepted strobe. The decision is remade at each strobe, including during a mixed pattern of good and bad packets.
- R7: While `pkt_stb`=0 and the mode is unchanged, `det_n` holds its value whatever `pkt_good` does.
- R8: A change of `sys_12k` clears the history and the count and drives `det_n` to 1 at the next edge. After the change, a full threshold of new good packets is needed to qualify.
- R9: A strobe that arrives in the same cycle as a change of `sys_12k` is dropped. It does not count toward the new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_12k | input | 1 | Tone system: 1 = 12 kHz, 0 = 16 kHz |
| pkt_stb | input | 1 | One-cycle strobe marking a packet verdict |
| pkt_good | input | 1 | Verdict for the strobed packet: 1 = good tone |
| det_n | output | 1 | Delayed tone follower, 0 = tone qualified |

## Verification
Two events can land in the same clock cycle: a packet strobe and a change of the tone system. The bench raises a good-packet strobe in the very cycle the mode input flips. It then feeds one fewer good packet than the new threshold and checks that `det_n` is still 1. It checks that `det_n` falls only on the next packet, which shows that the collided strobe was dropped and that the clear took priority.

// File: rtl/pwq_pkg.sv
// Package: shared types and helpers for the packet window qualifier.
// Assumes nothing beyond the standard; pure declarations.
package pwq_pkg;

    // Tone system selected by the mode input (value is the pin level)
    typedef enum logic {
        TONE_16K = 1'b0,
        TONE_12K = 1'b1
    } tone_sys_e;

    // Larger of two sizes, used to size the shared history
    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwq_history.sv
// Module: pwq_history
// Shift register of packet verdict flags, newest in bit 0. Presents the
// flag that leaves the window of the currently selected tone system.
// Assumes WIN_12K and WIN_16K are both between 1 and DEPTH, and DEPTH >= 2.
module pwq_history #(
    parameter int unsigned DEPTH   = 24,
    parameter int unsigned WIN_12K = 18,
    parameter int unsigned WIN_16K = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    input  logic sel_12k,
    output logic leaving
);

    logic [DEPTH-1:0] hist_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            logic feed;
            if (i == 0) begin : g_head
                assign feed = bit_in;
            end else begin : g_tail
                assign feed = hist_q[i-1];
            end

            // One history stage: clear, shift or hold
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    hist_q[i] <= 1'b0;
                end else if (shift_en) begin
                    hist_q[i] <= feed;
                end
            end
        end
    endgenerate

    // Oldest flag inside the selected window drops out on the next shift
    assign leaving = sel_12k ? hist_q[WIN_12K-1] : hist_q[WIN_16K-1];

endmodule

// File: rtl/pwq_counter.sv
// Module: pwq_counter
// Running count of good flags in the window, kept incrementally:
// the incoming flag is added and the leaving flag is subtracted.
// Assumes the history and this count are cleared together.
module pwq_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step_en,
    input  logic             add_bit,
    input  logic             sub_bit,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);

    // Next count for an accepted packet
    always_comb begin
        cnt_next = cnt_q;
        if (add_bit && !sub_bit) begin
            cnt_next = cnt_q + CNT_W'(1);
        end else if (!add_bit && sub_bit) begin
            cnt_next = cnt_q - CNT_W'(1);
        end
    end

    // Count register: clear, step on packet, else hold
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step_en) begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/pwq_decide.sv
// Module: pwq_decide
// Compares the post-update count against the threshold of the selected
// tone system and registers the active-low detect output.
// Assumes thresholds fit in CNT_W bits.
module pwq_decide #(
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned THR_12K = 15,
    parameter int unsigned THR_16K = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             update,
    input  logic             sel_12k,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             det_n
);

    localparam logic [CNT_W-1:0] LIM_12K = CNT_W'(THR_12K);
    localparam logic [CNT_W-1:0] LIM_16K = CNT_W'(THR_16K);

    logic [CNT_W-1:0] limit;
    logic             qualified;

    // Threshold for the active tone system
    assign limit     = sel_12k ? LIM_12K : LIM_16K;
    assign qualified = (cnt_next >= limit);

    // Output register: forced high on clear, re-decided on each packet
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            det_n <= 1'b1;
        end else if (update) begin
            det_n <= !qualified;
        end
    end

endmodule

// File: rtl/pkt_window_qual.sv
// Module: pkt_window_qual (top)
// k-of-n qualifier over a sliding window of packet verdicts. The window
// length and threshold follow the tone system input; a change of system
// clears all history. Assumes pkt_stb is a single-cycle pulse per packet.
module pkt_window_qual #(
    parameter int unsigned WIN_12K = 18,
    parameter int unsigned THR_12K = 15,
    parameter int unsigned WIN_16K = 24,
    parameter int unsigned THR_16K = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_12k,
    input  logic pkt_stb,
    input  logic pkt_good,
    output logic det_n
);

    import pwq_pkg::*;

    localparam int unsigned DEPTH = larger(WIN_12K, WIN_16K);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    tone_sys_e        mode_q;
    logic             mode_chg;
    logic             accept;
    logic             sel_12k;
    logic             leaving;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_next;

    // Track the tone system seen last cycle; reset assumes 12 kHz default
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TONE_12K;
        end else begin
            mode_q <= tone_sys_e'(sys_12k);
        end
    end

    assign mode_chg = (sys_12k != logic'(mode_q));
    assign accept   = pkt_stb && !mode_chg;
    assign sel_12k  = (mode_q == TONE_12K);

    pwq_history #(
        .DEPTH   (DEPTH),
        .WIN_12K (WIN_12K),
        .WIN_16K (WIN_16K)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (mode_chg),
        .shift_en (accept),
        .bit_in   (pkt_good),
        .sel_12k  (sel_12k),
        .leaving  (leaving)
    );

    pwq_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (mode_chg),
        .step_en  (accept),
        .add_bit  (pkt_good),
        .sub_bit  (leaving),
        .cnt_q    (count_q),
        .cnt_next (count_next)
    );

    pwq_decide #(
        .CNT_W   (CNT_W),
        .THR_12K (THR_12K),
        .THR_16K (THR_16K)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (mode_chg),
        .update   (accept),
        .sel_12k  (sel_12k),
        .cnt_next (count_next),
        .det_n    (det_n)
    );

endmodule

// File: rtl/pwq_checker.sv
// Module: pwq_checker
// Assertion checker for pkt_window_qual, attached with bind below.
// Assumes it sees the top's internal count and registered mode.
module pwq_checker #(
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned WIN_12K = 18,
    parameter int unsigned THR_12K = 15,
    parameter int unsigned WIN_16K = 24,
    parameter int unsigned THR_16K = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_12k,
    input logic             pkt_stb,
    input logic             mode_q,
    input logic [CNT_W-1:0] count_q,
    input logic             det_n
);

    logic [CNT_W-1:0] win_now;
    logic [CNT_W-1:0] thr_now;

    assign win_now = mode_q ? CNT_W'(WIN_12K) : CNT_W'(WIN_16K);
    assign thr_now = mode_q ? CNT_W'(THR_12K) : CNT_W'(THR_16K);

    // R1: reset leaves the output deasserted
    a_r1_reset_high: assert property (@(posedge clk) !rst_n |=> det_n);

    // R4: output and stored count agree with the threshold of the held mode
    a_r4_count_matches_output: assert property (@(posedge clk) disable iff (!rst_n)
        det_n == (count_q < thr_now));

    // R6: the count never exceeds the window of the held mode
    a_r6_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= win_now);

    // R7: without a strobe and without a mode change the output holds
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_stb && sys_12k == mode_q) |=> $stable(det_n));

    // R8: a change of tone system forces the output high and the count empty
    a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_12k != mode_q) |=> (det_n && count_q == '0));

endmodule

bind pkt_window_qual pwq_checker #(
    .CNT_W   (CNT_W),
    .WIN_12K (WIN_12K),
    .THR_12K (THR_12K),
    .WIN_16K (WIN_16K),
    .THR_16K (THR_16K)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_12k (sys_12k),
    .pkt_stb (pkt_stb),
    .mode_q  (sel_12k),
    .count_q (count_q),
    .det_n   (det_n)
);

// File: tb/pkt_window_qual_test.sv
// Bench: directed scenarios for pkt_window_qual, one task each, with a
// bench-side window model computed from the requirements.
module pkt_window_qual_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_12k = 1'b1;
    logic pkt_stb = 1'b0;
    logic pkt_good = 1'b0;
    logic det_n;

    int total = 0;
    int bad = 0;
    bit m_hist[$];
    logic m_det = 1'b1;

    pkt_window_qual uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_12k  (sys_12k),
        .pkt_stb  (pkt_stb),
        .pkt_good (pkt_good),
        .det_n    (det_n)
    );

    always #2 clk = ~clk;

    // Compare one value and report
    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: det_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Model: clear on mode change or reset
    task automatic m_clear();
        m_hist.delete();
        m_det = 1'b1;
    endtask

    // Model: accept a packet and decide
    task automatic m_push(input bit g);
        int win;
        int thr;
        int sum;
        win = sys_12k ? 18 : 24;
        thr = sys_12k ? 15 : 20;
        m_hist.push_front(g);
        sum = 0;
        for (int i = 0; i < m_hist.size() && i < win; i++) sum += m_hist[i];
        m_det = (sum >= thr) ? 1'b0 : 1'b1;
    endtask

    // Send one packet and check the decision
    task automatic send(input string req, input bit g);
        @(negedge clk);
        pkt_stb = 1'b1;
        pkt_good = g;
        m_push(g);
        @(negedge clk);
        pkt_stb = 1'b0;
        pkt_good = 1'b0;
        check(req, det_n, m_det);
    endtask

    // Change tone system and check the forced clear
    task automatic set_mode(input string req, input logic m);
        @(negedge clk);
        if (sys_12k != m) begin
            sys_12k = m;
            m_clear();
            @(negedge clk);
            check(req, det_n, 1'b1);
        end
    endtask

    task automatic t_reset();
        check("R1", det_n, 1'b1);
        for (int i = 0; i < 14; i++) send("R1", 1'b1);
        check("R1 14 good", det_n, 1'b1);
        send("R1", 1'b1);
        check("R1 15th good", det_n, 1'b0);
    endtask

    task automatic t_16k_run();
        set_mode("R8", 1'b0);
        for (int i = 0; i < 19; i++) send("R2", 1'b1);
        check("R2 after 19", det_n, 1'b1);
        send("R2", 1'b1);
        check("R2 after 20", det_n, 1'b0);
    endtask

    task automatic t_12k_run();
        set_mode("R8", 1'b1);
        for (int i = 0; i < 14; i++) send("R3", 1'b1);
        check("R3 after 14", det_n, 1'b1);
        send("R3", 1'b1);
        check("R3 after 15", det_n, 1'b0);
    endtask

    task automatic t_k_of_n();
        set_mode("R8", 1'b1);
        set_mode("R8", 1'b0);
        for (int i = 0; i < 24; i++) send("R4 four bad", (i % 6) != 2);
        check("R4 20 of 24", det_n, 1'b0);
        set_mode("R8", 1'b1);
        set_mode("R8", 1'b0);
        for (int i = 0; i < 24; i++) send("R4 five bad", (i % 5) != 2);
        check("R4 19 of 24", det_n, 1'b1);
    endtask

    task automatic t_drop();
        set_mode("R8", 1'b1);
        set_mode("R8", 1'b0);
        for (int i = 0; i < 20; i++) send("R5", 1'b1);
        for (int i = 0; i < 4; i++) send("R5 bad", 1'b0);
        check("R5 after 4 bad", det_n, 1'b0);
        send("R5 bad", 1'b0);
        check("R5 after 5 bad", det_n, 1'b1);
    endtask

    task automatic t_slide();
        for (int i = 0; i < 60; i++) send("R6", (i % 9) != 0 && (i % 13) != 5);
        for (int i = 0; i < 30; i++) send("R6", (i % 4) != 1);
    endtask

    task automatic t_hold();
        logic held;
        for (int i = 0; i < 24; i++) send("R7", 1'b1);
        held = det_n;
        check("R7 qualified", held, 1'b0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            pkt_good = ~pkt_good;
            check("R7 hold", det_n, held);
        end
        pkt_good = 1'b0;
    endtask

    task automatic t_mode_clear();
        set_mode("R8 to 12k", 1'b1);
        for (int i = 0; i < 14; i++) send("R8", 1'b1);
        check("R8 14 after clear", det_n, 1'b1);
        send("R8", 1'b1);
        check("R8 15 after clear", det_n, 1'b0);
    endtask

    task automatic t_collide();
        set_mode("R8", 1'b0);
        @(negedge clk);
        sys_12k = 1'b1;
        pkt_stb = 1'b1;
        pkt_good = 1'b1;
        m_clear();
        @(negedge clk);
        pkt_stb = 1'b0;
        pkt_good = 1'b0;
        check("R9 clear wins", det_n, 1'b1);
        for (int i = 0; i < 14; i++) send("R9", 1'b1);
        check("R9 dropped strobe", det_n, 1'b1);
        send("R9", 1'b1);
        check("R9 15th", det_n, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: det_n=%b expected finish", det_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_clear();
        @(negedge clk);
        t_reset();
        t_16k_run();
        t_12k_run();
        t_k_of_n();
        t_drop();
        t_slide();
        t_hold();
        t_mode_clear();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule